// File: doc/BRIEF.md
# Dynamic Bus Sizing Sequencer

This block is a bus master for a 32-bit, four-lane asynchronous-style bus. It accepts one operand of 1 to 4 bytes at any byte address and runs it as a series of bus cycles. On every cycle the slave returns a two-bit acknowledge that ends the cycle and reports the slave's port width (8, 16 or 32 bits). The master then works out how many bytes that port took and moves the address forward by that amount. If bytes are left, it starts another cycle with a smaller bytes-remaining code. No configuration is needed for any port width, and the width may differ from one cycle to the next.

Each cycle has two phases. In the start phase the address, size code and direction are presented together with a one-cycle cycle-start strobe. The first cycle of an operand also pulses an operand-start strobe. The data phase follows: the address and data strobes are held until a non-zero acknowledge arrives. Write bytes are driven so that a slave of any width finds them on the lanes it decodes. Read bytes are collected from whichever lanes the responding port used and packed into a right-aligned result. A lock output can span several operands so that a read-modify-write pair stays indivisible.

Top module: `bus_sizer`

## Requirements
- R1: While reset is asserted, and after it is released, `req_ready` is 1 and `bus_as`, `bus_ds`, `cyc_start`, `op_start` and `done` are 0.
- R2: In each start phase, `bus_addr` is the address of the first byte not yet transferred. `bus_siz` encodes the bytes still to move: 01 means 1, 10 means 2, 11 means 3 and 00 means 4. `req_size` uses the same encoding.
- R3: After an acknowledge, the bytes taken equal min(remaining, W - (address mod W)), where W is 1, 2 or 4 for acknowledge codes 01, 10 and 11. The next cycle starts at the address plus that count, and new cycles are issued until no bytes remain.
- R4: `cyc_start` is high for exactly the one start-phase clock of every bus cycle. `op_start` is high in that same clock only for the first cycle of an operand.
- R5: During the start phase `bus_as` and `bus_ds` are low. Both are high in the data phase, and they stay high with address and size stable for as long as `bus_ack` is 00 (wait).
- R6: Lane L is `bus_wdata[31-8L -: 8]`, and operand bytes are counted in transfer order, lowest address first. On a write, the first remaining byte and those after it appear on three sets of lanes at once: lanes o, o+1, ... with o = address mod 4; lanes (address mod 2), ... for a 16-bit port; and lane 0 for an 8-bit port.
- R7: On a read, byte j of a cycle is taken from lane (address mod W)+j. `rdata` holds the operand right-aligned, with the lowest-address byte most significant and the unused upper bytes zero.
- R8: `done` pulses for one clock, in the clock after the last acknowledge, with `req_ready` high. While an operand is in progress, `req_ready` is 0 and `req_valid` is ignored.
- R9: `bus_rmw` takes the value of `req_rmw` when an operand is accepted and holds through all of that operand's cycles. Between operands it stays high while `req_rmw` stays high, and it falls in idle once `req_rmw` is low.
- R10: `bus_rnw` is 1 for reads and 0 for writes, and it holds across all cycles of an operand.
- R11: The port width reported may differ between cycles of the same operand. Each cycle's byte count and lane choice follow that cycle's acknowledge code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Operand request |
| req_ready | output | 1 | Idle and able to accept a request |
| req_write | input | 1 | 1 = write operand, 0 = read operand |
| req_rmw | input | 1 | Lock request for indivisible sequences |
| req_size | input | 2 | Operand byte count (01/10/11/00 = 1/2/3/4) |
| req_addr | input | AW | Byte address of the operand |
| req_wdata | input | 32 | Write operand, right-aligned |
| done | output | 1 | One-clock completion pulse |
| rdata | output | 32 | Read operand, right-aligned |
| bus_addr | output | AW | Bus address |
| bus_siz | output | 2 | Bytes-remaining code |
| bus_wdata | output | 32 | Write lanes |
| bus_rdata | input | 32 | Read lanes |
| bus_ack | input | 2 | Acknowledge and port width (00 wait, 01 8-bit, 10 16-bit, 11 32-bit) |
| cyc_start | output | 1 | Start of every bus cycle |
| op_start | output | 1 | Start of the first bus cycle of an operand |
| bus_as | output | 1 | Address strobe, active high |
| bus_ds | output | 1 | Data strobe, active high |
| bus_rnw | output | 1 | Read (1) or write (0) |
| bus_rmw | output | 1 | Indivisible sequence lock |

## Verification
The assertions check the cycle framing every cycle. They cover the strobe sequence, holding the address and size through wait states, the address step and remaining-count drop after each acknowledge, a stable direction, the lock holding while busy, and the completion pulse. Lane steering and read packing depend on operand values and on which port answered. Only the bench scenarios can show these: they cover every operand size at every offset against 8-, 16- and 32-bit slaves, and ports that change width in mid-operand.

// File: rtl/bsz_pkg.sv
package bsz_pkg;
  localparam int unsigned LANES  = 4;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned DATA_W = LANES * BYTE_W;

  typedef logic [2:0] cnt_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_DATA  = 2'd2
  } seq_state_e;

  // operand size code: 00 means a full four bytes
  function automatic cnt_t size_to_count(input logic [1:0] code);
    cnt_t n;
    if (code == 2'b00) n = 3'd4;
    else               n = {1'b0, code};
    return n;
  endfunction

  // port width in bytes reported by an acknowledge code
  function automatic cnt_t port_bytes(input logic [1:0] ack);
    cnt_t w;
    case (ack)
      2'b01:   w = 3'd1;
      2'b10:   w = 3'd2;
      2'b11:   w = 3'd4;
      default: w = 3'd0;
    endcase
    return w;
  endfunction

  // byte offset of the address inside the responding port
  function automatic logic [1:0] port_offset(input logic [1:0] off, input logic [1:0] ack);
    logic [1:0] p;
    case (ack)
      2'b01:   p = 2'b00;
      2'b10:   p = {1'b0, off[0]};
      default: p = off;
    endcase
    return p;
  endfunction

  // bytes a port accepts: limited by what is left and by the port boundary
  function automatic cnt_t bytes_taken(input cnt_t rem, input logic [1:0] off,
                                       input logic [1:0] ack);
    cnt_t room;
    cnt_t n;
    if (ack == 2'b00) begin
      n = 3'd0;
    end else begin
      room = port_bytes(ack) - {1'b0, port_offset(off, ack)};
      n = (rem < room) ? rem : room;
    end
    return n;
  endfunction

  // index of the remaining byte driven on a write lane, chosen so that
  // 8-, 16- and 32-bit ports each find their bytes
  function automatic logic [1:0] wr_src(input logic [1:0] off, input logic [1:0] lane);
    logic [1:0] s;
    if (lane >= off)       s = lane - off;
    else if (off == 2'd2)  s = lane;
    else                   s = 2'd0;
    return s;
  endfunction
endpackage

// File: rtl/bsz_seq.sv
module bsz_seq
  import bsz_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          req_rmw,
  input  logic [1:0]    req_size,
  input  logic [AW-1:0] req_addr,
  input  logic [1:0]    bus_ack,
  output logic          accept,
  output logic          ack_evt,
  output logic          last_evt,
  output cnt_t          acc_bytes,
  output cnt_t          rem_cnt,
  output cnt_t          sent_cnt,
  output cnt_t          len_cnt,
  output logic [AW-1:0] addr_cur,
  output logic          write_cur,
  output logic          lock_cur,
  output logic          in_start,
  output logic          in_data,
  output logic          first_cyc,
  output logic          idle,
  output logic          done_pulse
);
  seq_state_e    state_q;
  logic [AW-1:0] addr_q;
  cnt_t          rem_q, sent_q, len_q;
  logic          write_q, lock_q, first_q, done_q;

  assign idle      = (state_q == ST_IDLE);
  assign in_start  = (state_q == ST_START);
  assign in_data   = (state_q == ST_DATA);
  assign accept    = idle && req_valid;
  assign ack_evt   = in_data && (bus_ack != 2'b00);
  assign acc_bytes = ack_evt ? bytes_taken(rem_q, addr_q[1:0], bus_ack) : 3'd0;
  assign last_evt  = ack_evt && (acc_bytes == rem_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      rem_q   <= '0;
      sent_q  <= '0;
      len_q   <= 3'd4;
      write_q <= 1'b0;
      lock_q  <= 1'b0;
      first_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          lock_q <= lock_q & req_rmw;
          if (req_valid) begin
            state_q <= ST_START;
            addr_q  <= req_addr;
            rem_q   <= size_to_count(req_size);
            len_q   <= size_to_count(req_size);
            sent_q  <= '0;
            write_q <= req_write;
            lock_q  <= req_rmw;
            first_q <= 1'b1;
          end
        end
        ST_START: state_q <= ST_DATA;
        ST_DATA: begin
          if (ack_evt) begin
            addr_q  <= addr_q + AW'(acc_bytes);
            rem_q   <= rem_q - acc_bytes;
            sent_q  <= sent_q + acc_bytes;
            first_q <= 1'b0;
            if (last_evt) begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
            end else begin
              state_q <= ST_START;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rem_cnt    = rem_q;
  assign sent_cnt   = sent_q;
  assign len_cnt    = len_q;
  assign addr_cur   = addr_q;
  assign write_cur  = write_q;
  assign lock_cur   = lock_q;
  assign first_cyc  = first_q;
  assign done_pulse = done_q;
endmodule

// File: rtl/bsz_wr_steer.sv
module bsz_wr_steer
  import bsz_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [1:0]        req_size,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              ack_evt,
  input  cnt_t              acc_bytes,
  input  cnt_t              rem_cnt,
  input  logic [1:0]        off,
  output logic [DATA_W-1:0] bus_wdata
);
  // remaining bytes kept left-aligned: next byte to send at the top
  logic [DATA_W-1:0] wbuf_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbuf_q <= '0;
    end else if (accept) begin
      wbuf_q <= req_wdata << (BYTE_W * (LANES - size_to_count(req_size)));
    end else if (ack_evt) begin
      wbuf_q <= wbuf_q << (BYTE_W * acc_bytes);
    end
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [1:0] src;
    logic       live;
    assign src  = wr_src(off, 2'(k));
    assign live = ({1'b0, src} < rem_cnt);
    assign bus_wdata[DATA_W-1-BYTE_W*k -: BYTE_W] =
      live ? wbuf_q[DATA_W-1-BYTE_W*src -: BYTE_W] : '0;
  end
endmodule

// File: rtl/bsz_rd_pack.sv
module bsz_rd_pack
  import bsz_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              ack_evt,
  input  logic              write_cur,
  input  cnt_t              acc_bytes,
  input  cnt_t              sent_cnt,
  input  cnt_t              len_cnt,
  input  logic [1:0]        off,
  input  logic [1:0]        bus_ack,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic [DATA_W-1:0] rdata
);
  // assembled bytes kept left-aligned in transfer order
  logic [DATA_W-1:0] rbuf;

  for (genvar s = 0; s < LANES; s++) begin : g_slot
    cnt_t            rel;
    logic            take;
    logic [1:0]      lane;
    logic [BYTE_W-1:0] slot_q;

    assign rel  = 3'(s) - sent_cnt;
    assign take = ack_evt && !write_cur && (3'(s) >= sent_cnt) && (rel < acc_bytes);
    assign lane = port_offset(off, bus_ack) + rel[1:0];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       slot_q <= '0;
      else if (accept)  slot_q <= '0;
      else if (take)    slot_q <= bus_rdata[DATA_W-1-BYTE_W*lane -: BYTE_W];
    end

    assign rbuf[DATA_W-1-BYTE_W*s -: BYTE_W] = slot_q;
  end

  assign rdata = rbuf >> (BYTE_W * (LANES - len_cnt));
endmodule

// File: rtl/bus_sizer.sv
module bus_sizer
  import bsz_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic          req_rmw,
  input  logic [1:0]    req_size,
  input  logic [AW-1:0] req_addr,
  input  logic [31:0]   req_wdata,
  output logic          done,
  output logic [31:0]   rdata,
  output logic [AW-1:0] bus_addr,
  output logic [1:0]    bus_siz,
  output logic [31:0]   bus_wdata,
  input  logic [31:0]   bus_rdata,
  input  logic [1:0]    bus_ack,
  output logic          cyc_start,
  output logic          op_start,
  output logic          bus_as,
  output logic          bus_ds,
  output logic          bus_rnw,
  output logic          bus_rmw
);
  logic          accept, ack_evt, last_evt;
  cnt_t          acc_bytes, rem_cnt, sent_cnt, len_cnt;
  logic [AW-1:0] addr_cur;
  logic          write_cur, lock_cur, in_start, in_data, first_cyc, idle, done_pulse;

  bsz_seq #(.AW(AW)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_rmw    (req_rmw),
    .req_size   (req_size),
    .req_addr   (req_addr),
    .bus_ack    (bus_ack),
    .accept     (accept),
    .ack_evt    (ack_evt),
    .last_evt   (last_evt),
    .acc_bytes  (acc_bytes),
    .rem_cnt    (rem_cnt),
    .sent_cnt   (sent_cnt),
    .len_cnt    (len_cnt),
    .addr_cur   (addr_cur),
    .write_cur  (write_cur),
    .lock_cur   (lock_cur),
    .in_start   (in_start),
    .in_data    (in_data),
    .first_cyc  (first_cyc),
    .idle       (idle),
    .done_pulse (done_pulse)
  );

  bsz_wr_steer u_wr (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .req_size  (req_size),
    .req_wdata (req_wdata),
    .ack_evt   (ack_evt),
    .acc_bytes (acc_bytes),
    .rem_cnt   (rem_cnt),
    .off       (addr_cur[1:0]),
    .bus_wdata (bus_wdata)
  );

  bsz_rd_pack u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .ack_evt   (ack_evt),
    .write_cur (write_cur),
    .acc_bytes (acc_bytes),
    .sent_cnt  (sent_cnt),
    .len_cnt   (len_cnt),
    .off       (addr_cur[1:0]),
    .bus_ack   (bus_ack),
    .bus_rdata (bus_rdata),
    .rdata     (rdata)
  );

  assign req_ready = idle;
  assign done      = done_pulse;
  assign bus_addr  = addr_cur;
  assign bus_siz   = rem_cnt[1:0];
  assign cyc_start = in_start;
  assign op_start  = in_start && first_cyc;
  assign bus_as    = in_data;
  assign bus_ds    = in_data;
  assign bus_rnw   = !write_cur;
  assign bus_rmw   = lock_cur;
endmodule

// File: rtl/bus_sizer_chk.sv
module bus_sizer_chk
  import bsz_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          done,
  input logic          bus_as,
  input logic          bus_ds,
  input logic [1:0]    bus_ack,
  input logic [AW-1:0] bus_addr,
  input logic [1:0]    bus_siz,
  input logic          bus_rnw,
  input logic          bus_rmw,
  input logic          cyc_start,
  input logic          op_start,
  input logic          ack_evt,
  input cnt_t          acc_bytes,
  input cnt_t          rem_cnt
);
  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |-> req_ready && !bus_as && !cyc_start && !done); // R1
  AST_START_THEN_STROBE: assert property (@(posedge clk) disable iff (!rst_n) cyc_start |=> !cyc_start && bus_as && bus_ds); // R4
  AST_OPSTART_IN_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) op_start |-> cyc_start && !bus_as); // R4
  AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (bus_as && bus_ack == 2'b00) |=> bus_as && bus_ds && $stable(bus_addr) && $stable(bus_siz)); // R5
  AST_TAKE_RANGE: assert property (@(posedge clk) disable iff (!rst_n) ack_evt |-> acc_bytes != 3'd0 && acc_bytes <= rem_cnt); // R3
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n) (ack_evt && acc_bytes != rem_cnt) |=> cyc_start && bus_addr == $past(bus_addr) + AW'($past(acc_bytes)) && bus_siz == 2'($past(rem_cnt) - $past(acc_bytes))); // R3
  AST_LAST_DONE: assert property (@(posedge clk) disable iff (!rst_n) (ack_evt && acc_bytes == rem_cnt) |=> done && req_ready); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R8
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n) (bus_as || cyc_start) |-> !req_ready); // R8
  AST_DIR_STABLE: assert property (@(posedge clk) disable iff (!rst_n) (bus_as || cyc_start) |=> $stable(bus_rnw) || req_ready); // R10
  AST_LOCK_HELD: assert property (@(posedge clk) disable iff (!rst_n) (bus_rmw && !req_ready) |=> bus_rmw); // R9
endmodule

bind bus_sizer bus_sizer_chk #(.AW(AW)) u_chk (.*);

// File: tb/bus_sizer_tb.sv
module bus_sizer_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready, req_write, req_rmw;
  logic [1:0]  req_size;
  logic [31:0] req_addr, req_wdata;
  logic        done;
  logic [31:0] rdata, bus_addr, bus_wdata, bus_rdata;
  logic [1:0]  bus_siz, bus_ack;
  logic        cyc_start, op_start, bus_as, bus_ds, bus_rnw, bus_rmw;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  bus_sizer u_dut (.*);

  // {ack mode (00 = rotate 8/16/32 per cycle), write, wait states}
  localparam logic [4:0] ROWS [8] = '{
    5'b11_0_00, 5'b11_1_01, 5'b10_0_01, 5'b10_1_00,
    5'b01_0_00, 5'b01_1_10, 5'b00_0_00, 5'b00_1_01
  };

  function automatic logic [7:0] mem_byte(input logic [31:0] a);
    return 8'(a * 29 + 5);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic [1:0] mode, input logic wr, input int waits,
                        input logic [31:0] addr, input int len, input logic lock,
                        input logic poke);
    logic [31:0] a, wv, exp_rd, drv;
    int rem, sent, w, o, acc, cyc;
    logic [1:0] code;
    wv = (32'h9C3E_57A1 ^ addr) & ((len == 4) ? 32'hFFFF_FFFF : ((32'd1 << (8*len)) - 1));
    exp_rd = '0;
    for (int i = 0; i < len; i++) exp_rd = (exp_rd << 8) | 32'(mem_byte(addr + 32'(i)));
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_rmw = lock;
    req_size = 2'(len); req_addr = addr; req_wdata = wv;
    @(negedge clk);
    if (poke) begin req_addr = 32'hFFFF_FF00; req_write = ~wr; end
    else req_valid = 1'b0;
    a = addr; rem = len; sent = 0; cyc = 0;
    while (rem > 0) begin
      chk("R4 cyc_start", 32'(cyc_start), 1);
      chk("R4 op_start", 32'(op_start), (cyc == 0) ? 1 : 0);
      chk("R5 as low in start", 32'(bus_as | bus_ds), 0);
      chk("R2 address", bus_addr, a);
      chk("R2 size code", 32'(bus_siz), 32'(rem % 4));
      chk("R10 direction", 32'(bus_rnw), wr ? 0 : 1);
      chk("R8 busy", 32'(req_ready), 0);
      chk("R9 lock", 32'(bus_rmw), 32'(lock));
      @(negedge clk);
      for (int k = 0; k < waits; k++) begin
        bus_ack = 2'b00;
        chk("R5 strobes held", 32'({bus_as, bus_ds}), 3);
        @(negedge clk);
        chk("R5 address held", bus_addr, a);
      end
      chk("R5 strobes", 32'({bus_as, bus_ds}), 3);
      code = (mode != 2'b00) ? mode : 2'((cyc % 3) + 1);
      w = (code == 2'b01) ? 1 : (code == 2'b10) ? 2 : 4;
      o = int'(a % 32'(w));
      acc = (rem < w - o) ? rem : w - o;
      if (wr) begin
        for (int j = 0; j < acc; j++)
          chk((mode == 2'b00) ? "R11 write lane" : "R6 write lane",
              32'(bus_wdata[31-8*(o+j) -: 8]), 32'(wv[8*(len-1-sent-j) +: 8]));
      end else begin
        drv = 32'hEEEE_EEEE;
        for (int l = 0; l < w; l++) drv[31-8*l -: 8] = mem_byte(a - 32'(o) + 32'(l));
        bus_rdata = drv;
      end
      if (poke && acc == rem) req_valid = 1'b0;
      bus_ack = code;
      @(negedge clk);
      bus_ack = 2'b00; bus_rdata = 32'hDEAD_BEEF;
      a = a + 32'(acc); rem = rem - acc; sent = sent + acc; cyc++;
    end
    chk("R8 done", 32'(done), 1);
    chk("R8 ready", 32'(req_ready), 1);
    chk("R4 no start after last", 32'(cyc_start), 0);
    if (!wr) chk((mode == 2'b00) ? "R11 read data" : "R7 read data", rdata, exp_rd);
    @(negedge clk);
    chk("R8 done pulse", 32'(done), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_rmw = 1'b0;
    req_size = 2'b00; req_addr = '0; req_wdata = '0;
    bus_ack = 2'b00; bus_rdata = 32'hDEAD_BEEF;
    repeat (2) @(negedge clk);
    chk("R1 ready in reset", 32'(req_ready), 1);
    chk("R1 strobes in reset", 32'({bus_as, bus_ds, cyc_start, op_start, done}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready after reset", 32'(req_ready), 1);
    chk("R1 quiet after reset", 32'({bus_as, bus_ds, cyc_start, done}), 0);

    for (int r = 0; r < 8; r++)
      for (int off = 0; off < 4; off++)
        for (int len = 1; len <= 4; len++)
          run_op(ROWS[r][4:3], ROWS[r][2], int'(ROWS[r][1:0]),
                 32'h0040_1000 + 32'(r * 64 + len * 8 + off), len, 1'b0, 1'b0);

    // R9: lock held from read through idle into write, then released in idle
    run_op(2'b01, 1'b0, 0, 32'h0000_2001, 4, 1'b1, 1'b0);
    chk("R9 lock across idle", 32'(bus_rmw), 1);
    run_op(2'b10, 1'b1, 1, 32'h0000_2001, 4, 1'b1, 1'b0);
    req_rmw = 1'b0;
    @(negedge clk);
    chk("R9 lock released", 32'(bus_rmw), 0);
    run_op(2'b11, 1'b0, 0, 32'h0000_2002, 2, 1'b0, 1'b0);
    chk("R9 no lock", 32'(bus_rmw), 0);

    // R8: request held high while busy must not disturb the operand
    run_op(2'b01, 1'b1, 0, 32'h0000_3003, 4, 1'b0, 1'b1);
    run_op(2'b00, 1'b0, 1, 32'h0000_3001, 3, 1'b0, 1'b1);
    @(negedge clk);
    chk("R8 idle after ignored request", 32'(cyc_start | bus_as), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule